// File: doc/BRIEF.md
# Timer Channel: Capture, Compare and PWM

This block is one channel of a general-purpose timer. A free-running counter value, a count-direction indication and an overflow strobe come in from logic shared by all channels. A small configuration word selects what the channel does with them. It can latch the counter when the input pin shows a chosen edge, act on the output pin when the counter equals a stored value, or produce an edge-aligned or a center-aligned pulse-width-modulated waveform.

The channel keeps one 16-bit value register that software may write and read. In capture mode it receives the counter value. In every other mode it holds the value the counter is compared against. Every capture and every compare match raises a status flag, and software clears that flag with a write-one strobe. When the edge/level field is zero, the pin is released to other use and the output enable is dropped.

Top module: `tmr_chan`

## Requirements
- R1: After synchronous reset the value register reads 0, the flag is 0, the pin output is 0 and the output enable is 0.
- R2: With center select 0, mode 00 and edge field 01, a rising edge on the input pin copies the counter into the value register and sets the flag. A falling edge changes neither.
- R3: In capture mode, edge field 10 captures only on falling edges, and edge field 11 captures on both edges.
- R4: An edge field of 00 in capture mode blocks every capture. An edge field of 00 in any mode keeps the output enable at 0.
- R5: With center select 0 and mode 01, a compare match (counter equal to value register) acts on the pin according to the edge field. 01 toggles the pin, 10 drives it to 0 and 11 drives it to 1. 00 leaves the pin unchanged and still sets the flag.
- R6: With center select 0 and mode 1x, the block produces edge-aligned PWM. The overflow strobe drives the pin to the active level, and a compare match drives it to the inactive level. If both come in the same cycle, the match wins. Edge field 10 makes the active level 1, and edge field 01 or 11 makes it 0.
- R7: With center select 1, the mode bits are ignored and the block produces center-aligned PWM. A match while counting up drives the pin to the inactive level. A match while counting down drives it to the active level. Overflow has no effect on the pin. The active level is chosen as in R6.
- R8: The flag is set by every capture and every compare match. A flag-clear strobe clears it, but an event in the same cycle as the strobe leaves the flag set.
- R9: A value write loads the value register, which reads back directly. A capture in the same cycle as a write takes priority.
- R10: The output enable is 1 in the compare and PWM modes when the edge field is not 00. It is 0 in capture mode.
- R11: The input pin passes through a two-flop synchronizer. A pin change applied before clock edge 1 is captured at clock edge 3, using the counter value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_down | input | 1 | 1 while the shared counter counts down |
| cnt_ovf | input | 1 | Counter overflow strobe |
| cfg_center | input | 1 | Center-aligned PWM select |
| cfg_mode | input | 2 | Mode bits |
| cfg_edge | input | 2 | Edge/level field |
| val_wr | input | 1 | Value register write strobe |
| val_wdata | input | 16 | Value register write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pin_in | input | 1 | Asynchronous input pin |
| val_rdata | output | 16 | Value register contents |
| flag | output | 1 | Channel event flag |
| pin_out | output | 1 | Timer output level |
| pin_oe | output | 1 | Timer output enable |

## Verification
Two collisions are the hardest cases to reach from the ports. One is a capture landing in the same cycle as a software write. The other is a compare match landing in the same cycle as a flag clear. For the first, the bench counts the synchronizer delay exactly. It raises the pin and then asserts the write strobe two cycles later, so that the write meets the detected edge at the third clock. For the second, it puts the matching counter value and the clear strobe in the same cycle. In both cases it then checks that the event won.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CH_CAPTURE = 2'd0,
        CH_COMPARE = 2'd1,
        CH_EPWM    = 2'd2,
        CH_CPWM    = 2'd3
    } ch_kind_e;

    typedef struct packed {
        ch_kind_e   kind;
        logic       pin_on;   // edge/level field non-zero
        logic       act_lvl;  // PWM active level
        logic [1:0] els;
    } ch_cfg_t;

    function automatic ch_kind_e kind_of(input logic center, input logic [1:0] mode);
        if (center)             return CH_CPWM;
        else if (mode[1])       return CH_EPWM;
        else if (mode == 2'b01) return CH_COMPARE;
        else                    return CH_CAPTURE;
    endfunction

endpackage

// File: rtl/tmr_chan_decode.sv
module tmr_chan_decode
    import tmr_chan_pkg::*;
(
    input  logic       center,
    input  logic [1:0] mode,
    input  logic [1:0] els,
    output ch_cfg_t    cfg
);
    always_comb begin
        cfg.kind    = kind_of(center, mode);
        cfg.pin_on  = (els != 2'b00);
        cfg.act_lvl = (els == 2'b10);
        cfg.els     = els;
    end
endmodule

// File: rtl/tmr_chan_insync.sv
module tmr_chan_insync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], pin_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;
    assign fall = ~chain[LAST] & prev;
endmodule

// File: rtl/tmr_chan_pinctl.sv
module tmr_chan_pinctl
    import tmr_chan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_cfg_t cfg,
    input  logic    match,
    input  logic    cnt_down,
    input  logic    cnt_ovf,
    output logic    pin_q,
    output logic    pin_oe
);
    logic pin_d;

    always_comb begin
        pin_d = pin_q;
        unique case (cfg.kind)
            CH_COMPARE: begin
                if (match) begin
                    unique case (cfg.els)
                        2'b01:   pin_d = ~pin_q;
                        2'b10:   pin_d = 1'b0;
                        2'b11:   pin_d = 1'b1;
                        default: pin_d = pin_q;
                    endcase
                end
            end
            CH_EPWM: begin
                if (cfg.pin_on) begin
                    if (match)        pin_d = ~cfg.act_lvl;
                    else if (cnt_ovf) pin_d = cfg.act_lvl;
                end
            end
            CH_CPWM: begin
                if (cfg.pin_on && match)
                    pin_d = cnt_down ? cfg.act_lvl : ~cfg.act_lvl;
            end
            default: pin_d = pin_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_d;
    end

    assign pin_oe = cfg.pin_on && (cfg.kind != CH_CAPTURE);

    a_r5_sw_compare_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == CH_COMPARE && cfg.els == 2'b00) |=> $stable(pin_q));

    a_r6_epwm_match_inactive: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == CH_EPWM && cfg.pin_on && match) |=> (pin_q == !$past(cfg.act_lvl)));

    a_r7_cpwm_down_active: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == CH_CPWM && cfg.pin_on && match && cnt_down) |=> (pin_q == $past(cfg.act_lvl)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int VAL_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             cnt_ovf,
    input  logic             cfg_center,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_edge,
    input  logic             val_wr,
    input  logic [VAL_W-1:0] val_wdata,
    input  logic             flag_clr,
    input  logic             pin_in,
    output logic [VAL_W-1:0] val_rdata,
    output logic             flag,
    output logic             pin_out,
    output logic             pin_oe
);
    ch_cfg_t          cfg;
    logic             rise, fall;
    logic             match, cap_evt, cmp_evt, evt;
    logic [VAL_W-1:0] val_q;
    logic             flag_q;

    tmr_chan_decode u_decode (
        .center (cfg_center),
        .mode   (cfg_mode),
        .els    (cfg_edge),
        .cfg    (cfg)
    );

    tmr_chan_insync #(.SYNC_STAGES(SYNC_STAGES)) u_insync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    assign match   = (cnt_val == val_q);
    assign cap_evt = (cfg.kind == CH_CAPTURE) &&
                     ((cfg.els[0] && rise) || (cfg.els[1] && fall));
    assign cmp_evt = (cfg.kind != CH_CAPTURE) && match;
    assign evt     = cap_evt || cmp_evt;

    always_ff @(posedge clk) begin
        if (rst)          val_q <= '0;
        else if (cap_evt) val_q <= cnt_val;
        else if (val_wr)  val_q <= val_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (evt)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    tmr_chan_pinctl u_pinctl (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .match    (match),
        .cnt_down (cnt_down),
        .cnt_ovf  (cnt_ovf),
        .pin_q    (pin_out),
        .pin_oe   (pin_oe)
    );

    assign val_rdata = val_q;
    assign flag      = flag_q;

    a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);

    a_r8_clear_without_event: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !evt) |=> !flag);

    a_r2_capture_loads_counter: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (val_rdata == $past(cnt_val)));

    a_r10_no_oe_in_capture: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == CH_CAPTURE) |-> !pin_oe);

    a_r4_edge_off_no_capture: assert property (@(posedge clk) disable iff (rst)
        (cfg.els == 2'b00 && !val_wr) |=> $stable(val_rdata));
endmodule

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_down = 1'b0, cnt_ovf = 1'b0;
    logic        cfg_center = 1'b0;
    logic [1:0]  cfg_mode = 2'b00, cfg_edge = 2'b00;
    logic        val_wr = 1'b0;
    logic [15:0] val_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] val_rdata;
    logic        flag, pin_out, pin_oe;

    tmr_chan i_tmr_chan (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down), .cnt_ovf(cnt_ovf),
        .cfg_center(cfg_center), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
        .val_wr(val_wr), .val_wdata(val_wdata), .flag_clr(flag_clr), .pin_in(pin_in),
        .val_rdata(val_rdata), .flag(flag), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       req;
        int          sel;   // 0 value, 1 flag, 2 pin, 3 oe
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.sel)
                0:       act = val_rdata;
                1:       act = {15'd0, flag};
                2:       act = {15'd0, pin_out};
                default: act = {15'd0, pin_oe};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_out(input string req, input int sel, input logic [15:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        val_wr = 1'b1; val_wdata = d; cyc(); val_wr = 1'b0;
    endtask

    task automatic setcfg(input logic c, input logic [1:0] m, input logic [1:0] e);
        cfg_center = c; cfg_mode = m; cfg_edge = e;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc();
        // R1 reset state
        expect_out("R1", 0, 16'h0000); expect_out("R1", 1, 0);
        expect_out("R1", 2, 0);        expect_out("R1", 3, 0);

        // R9 write and read back (capture mode, rising edge)
        setcfg(0, 2'b00, 2'b01);
        cnt_val = 16'h0AAA;
        wr(16'h1234);
        expect_out("R9", 0, 16'h1234);
        clr();

        // R11 / R2 rising-edge capture timing
        pin_in = 1'b1;
        cyc(2);
        expect_out("R11", 0, 16'h1234);
        cyc();
        expect_out("R11", 0, 16'h0AAA); expect_out("R2", 1, 1);
        expect_out("R10", 3, 0);
        clr();
        expect_out("R8", 1, 0);
        cnt_val = 16'h0BBB; pin_in = 1'b0; cyc(4);
        expect_out("R2", 0, 16'h0AAA); expect_out("R2", 1, 0);

        // R3 falling only
        setcfg(0, 2'b00, 2'b10);
        cnt_val = 16'h0CCC; pin_in = 1'b1; cyc(4);
        expect_out("R3", 0, 16'h0AAA); expect_out("R3", 1, 0);
        pin_in = 1'b0; cyc(4);
        expect_out("R3", 0, 16'h0CCC); expect_out("R3", 1, 1);
        clr();
        // R3 both edges
        setcfg(0, 2'b00, 2'b11);
        cnt_val = 16'h0DDD; pin_in = 1'b1; cyc(4);
        expect_out("R3", 0, 16'h0DDD);
        clr();
        cnt_val = 16'h0EEE; pin_in = 1'b0; cyc(4);
        expect_out("R3", 0, 16'h0EEE); expect_out("R3", 1, 1);
        clr();

        // R4 edge field zero blocks capture
        setcfg(0, 2'b00, 2'b00);
        cnt_val = 16'h0FFF; pin_in = 1'b1; cyc(4);
        expect_out("R4", 0, 16'h0EEE); expect_out("R4", 1, 0); expect_out("R4", 3, 0);

        // R9 capture beats a same-cycle write
        setcfg(0, 2'b00, 2'b01);
        pin_in = 1'b0; cyc(4); clr();
        pin_in = 1'b1; cyc(2);
        cnt_val = 16'h0123; val_wr = 1'b1; val_wdata = 16'h5555; cyc(); val_wr = 1'b0;
        expect_out("R9", 0, 16'h0123); expect_out("R9", 1, 1);

        // R5 software-only compare, R8 event beats clear
        setcfg(0, 2'b01, 2'b00);
        cnt_val = 16'h0000; wr(16'h0040); clr();
        cnt_val = 16'h0040; flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        expect_out("R8", 1, 1); expect_out("R5", 2, 0); expect_out("R4", 3, 0);
        cnt_val = 16'h0041; flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        expect_out("R8", 1, 0);

        // R5 toggle / set / clear
        cfg_edge = 2'b01; cnt_val = 16'h0040; cyc();
        expect_out("R5", 2, 1); expect_out("R10", 3, 1); expect_out("R5", 1, 1);
        cnt_val = 16'h0041; cyc();
        expect_out("R5", 2, 1);
        cnt_val = 16'h0040; cyc();
        expect_out("R5", 2, 0);
        cfg_edge = 2'b11; cnt_val = 16'h0041; cyc();
        cnt_val = 16'h0040; cyc();
        expect_out("R5", 2, 1);
        cfg_edge = 2'b10; cyc();
        expect_out("R5", 2, 0);

        // R6 edge-aligned PWM, high-true
        setcfg(0, 2'b10, 2'b10);
        cnt_val = 16'h0100; wr(16'h0005); clr();
        cnt_val = 16'h0000; cnt_ovf = 1'b1; cyc(); cnt_ovf = 1'b0;
        expect_out("R6", 2, 1);
        cnt_val = 16'h0003; cyc();
        expect_out("R6", 2, 1);
        cnt_val = 16'h0005; cyc();
        expect_out("R6", 2, 0); expect_out("R8", 1, 1);
        cnt_val = 16'h0006; cyc();
        expect_out("R6", 2, 0);
        // R6 match and overflow together: match wins
        cnt_val = 16'h0005; cnt_ovf = 1'b1; cyc(); cnt_ovf = 1'b0;
        expect_out("R6", 2, 0);
        // R6 low-true
        cfg_edge = 2'b01;
        cnt_val = 16'h0000; cnt_ovf = 1'b1; cyc(); cnt_ovf = 1'b0;
        expect_out("R6", 2, 0);
        cnt_val = 16'h0005; cyc();
        expect_out("R6", 2, 1);
        setcfg(0, 2'b11, 2'b11);
        cnt_val = 16'h0000; cnt_ovf = 1'b1; cyc(); cnt_ovf = 1'b0;
        expect_out("R6", 2, 0);

        // R7 center-aligned PWM, high-true
        setcfg(1, 2'b01, 2'b10);
        cnt_val = 16'h0005; cnt_down = 1'b0; cyc();
        expect_out("R7", 2, 0);
        cnt_down = 1'b1; cyc();
        expect_out("R7", 2, 1);
        cnt_val = 16'h0004; cyc();
        expect_out("R7", 2, 1);
        cnt_val = 16'h0000; cnt_ovf = 1'b1; cnt_down = 1'b0; cyc(); cnt_ovf = 1'b0;
        expect_out("R7", 2, 1);
        // R7 low-true
        cfg_edge = 2'b01;
        cnt_val = 16'h0005; cnt_down = 1'b0; cyc();
        expect_out("R7", 2, 1);
        cnt_down = 1'b1; cyc();
        expect_out("R7", 2, 0);
        // R7 mode bits ignored
        setcfg(1, 2'b00, 2'b10);
        cnt_down = 1'b1; cyc();
        expect_out("R7", 2, 1); expect_out("R10", 3, 1);
        cnt_down = 1'b0; cyc();
        expect_out("R7", 2, 0);

        cyc(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule